// File: doc/BRIEF.md
# SPI Event, Mask and Command Register Front End

This block is the software-facing control and status layer of an SPI controller. It turns single-cycle strobes from the serial engine and the buffer logic into sticky event flags. A matching mask register selects which flags raise the interrupt line. A command register carries a start bit that clears itself. The shift engine, the buffer handling and the FIFOs sit outside; only their strobes and the start-related pulses cross the boundary.

Software uses a small register port: a 2-bit address, a write strobe and an 8-bit write bus, with read data returned combinationally. Address 0 selects the event register, address 1 the mask and address 2 the command register. Address 3 reads as zero. Bits are numbered from the most significant end, so bit 0 is `reg_wdata[7]`.

The live event flags, by bit number, are these: bit 7 (`[0]`) receive buffer closed, bit 6 (`[1]`) transmit buffer done, bit 5 (`[2]`) receive character dropped, bit 3 (`[4]`) transmit error and bit 2 (`[5]`) multimaster conflict. Bits 0, 1 and 4 (`[7]`, `[6]`, `[3]`) are reserved. A start command is handled by a five-state sequencer:
- **CMD_IDLE** goes to CMD_MSTART in master mode.
- In slave mode it goes to CMD_SLOAD, but only when the engine is idle.
- CMD_MSTART always returns to CMD_IDLE.
- CMD_SLOAD always moves on to CMD_ARMED.
- CMD_ARMED goes to CMD_SBEGIN on a serial clock edge seen while slave select is active.
- CMD_SBEGIN always returns to CMD_IDLE.

Top module: `spi_evt_ctl`

## Requirements
- R1: After the asynchronous hard reset, and after a cycle with the synchronous soft reset high, the event, mask and command registers read 0x00. After either reset, `irq`, `start_pulse`, `load_tx` and `shift_go` are 0, and any armed slave start is dropped.
- R2: Reserved positions read as 0 in both the event and the mask register, even after writing 0xFF. The live-bit pattern is 0x37.
- R3: A one-cycle pulse on `ev_txerr`, `ev_rxdrop`, `ev_txdone` or `ev_rxclosed` sets, respectively, event value 0x10, 0x04, 0x02 or 0x01. That bit stays set after the pulse ends.
- R4: In any cycle where `master_mode` and `ss_active` are both 1, event bit 0x20 sets. With `master_mode` at 0, `ss_active` has no effect on the event register.
- R5: Writing the event register clears each bit written as 1. Bits written as 0 keep their value.
- R6: If a set strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: `irq` is 1 exactly when some event bit and its mask bit are both 1. It follows register changes in the cycle after the write or strobe.
- R8: In master mode, a write to the command register with `reg_wdata[7]` = 1 raises `start_pulse` for exactly one cycle, starting the cycle after the write. The command register reads 0x80 in that cycle only. A command write with `reg_wdata[7]` = 0 has no effect.
- R9: In slave mode with `engine_idle` = 1, a start write raises `load_tx` for one cycle after the write. After that, `shift_go` pulses for one cycle after the first clock edge on which `sclk_edge` and `ss_active` are both 1.
- R10: In slave mode with `engine_idle` = 0, a start write is ignored. No `load_tx` follows, and the command register stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| reg_addr | input | 2 | Register select: 0 event, 1 mask, 2 command |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data, bit 0 is reg_wdata[7] |
| reg_rdata | output | 8 | Read data of the selected register |
| master_mode | input | 1 | 1 when the controller is configured as master |
| ss_active | input | 1 | External slave select is active |
| sclk_edge | input | 1 | One-cycle strobe per serial clock edge |
| engine_idle | input | 1 | Serial engine has no transfer in progress |
| ev_txerr | input | 1 | Transmit error strobe |
| ev_rxdrop | input | 1 | Received character discarded, no buffer |
| ev_txdone | input | 1 | Last transmit character pushed to FIFO |
| ev_rxclosed | input | 1 | Receive buffer filled and closed |
| irq | output | 1 | Interrupt, OR of event AND mask |
| start_pulse | output | 1 | One-cycle master start toward the engine |
| load_tx | output | 1 | One-cycle slave transmit-register load |
| shift_go | output | 1 | One-cycle slave shift start |

## Verification
The bench targets the collision of a set strobe and a clearing write on the same bit. A design that lets the clear win would lose an event. It also checks that writing zeros to the event register changes nothing; a plain-write design would wipe every flag. The start bit is sampled on the cycle after it was written and the cycle after that, which exposes a bit that never clears or a pulse two cycles long. For slave starts, the bench shows that a serial clock edge without slave select does not release the shift. It also shows that a start written while the engine is busy leaves no load pulse and no command bit behind.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // Vector index of each live flag (bit 0 is the MSB, so index = 7 - bit number)
    localparam int IDX_MME = 5;
    localparam int IDX_TXE = 4;
    localparam int IDX_BSY = 2;
    localparam int IDX_TXB = 1;
    localparam int IDX_RXB = 0;

    localparam logic [REG_W-1:0] LIVE_MASK = (REG_W'(1) << IDX_MME) | (REG_W'(1) << IDX_TXE)
                                           | (REG_W'(1) << IDX_BSY) | (REG_W'(1) << IDX_TXB)
                                           | (REG_W'(1) << IDX_RXB);

    localparam logic [ADDR_W-1:0] ADDR_EVT  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(2);

    localparam int STR_IDX = REG_W - 1;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_MSTART,
        CMD_SLOAD,
        CMD_ARMED,
        CMD_SBEGIN
    } cmd_state_e;

endpackage

// File: rtl/spi_evt_bank.sv
module spi_evt_bank
    import spi_evt_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         hard_rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] evt_q
);

    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_wr ? clr_data : '0;
    end

    // One sticky flop per position; reserved positions are held at zero.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge hard_rst_n) begin
            if (!hard_rst_n) begin
                evt_q[i] <= 1'b0;
            end else if (soft_rst) begin
                evt_q[i] <= 1'b0;
            end else begin
                evt_q[i] <= ((evt_q[i] & ~clr_eff[i]) | set_vec[i]) & LIVE_MASK[i];
            end
        end
    end

endmodule

// File: rtl/spi_mask_reg.sv
module spi_mask_reg
    import spi_evt_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         hard_rst_n,
    input  logic         soft_rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            mask_q <= '0;
        end else if (soft_rst) begin
            mask_q <= '0;
        end else if (wr) begin
            mask_q <= wdata & LIVE_MASK[W-1:0];
        end
    end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_evt_pkg::*;
(
    input  logic clk,
    input  logic hard_rst_n,
    input  logic soft_rst,
    input  logic str_wr,
    input  logic master_mode,
    input  logic engine_idle,
    input  logic ss_active,
    input  logic sclk_edge,
    output logic start_pulse,
    output logic load_tx,
    output logic shift_go,
    output logic str_bit
);

    cmd_state_e state_q;
    cmd_state_e state_d;

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            state_q <= CMD_IDLE;
        end else if (soft_rst) begin
            state_q <= CMD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (str_wr) begin
                    if (master_mode) begin
                        state_d = CMD_MSTART;
                    end else if (engine_idle) begin
                        state_d = CMD_SLOAD;
                    end
                end
            end
            CMD_MSTART: state_d = CMD_IDLE;
            CMD_SLOAD:  state_d = CMD_ARMED;
            CMD_ARMED: begin
                if (ss_active && sclk_edge) begin
                    state_d = CMD_SBEGIN;
                end
            end
            CMD_SBEGIN: state_d = CMD_IDLE;
            default:    state_d = CMD_IDLE;
        endcase
    end

    always_comb begin
        start_pulse = 1'b0;
        load_tx     = 1'b0;
        shift_go    = 1'b0;
        str_bit     = 1'b0;
        unique case (state_q)
            CMD_IDLE:   ;
            CMD_MSTART: begin
                start_pulse = 1'b1;
                str_bit     = 1'b1;
            end
            CMD_SLOAD: begin
                load_tx = 1'b1;
                str_bit = 1'b1;
            end
            CMD_ARMED:  ;
            CMD_SBEGIN: shift_go = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/spi_evt_ctl.sv
module spi_evt_ctl
    import spi_evt_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              master_mode,
    input  logic              ss_active,
    input  logic              sclk_edge,
    input  logic              engine_idle,
    input  logic              ev_txerr,
    input  logic              ev_rxdrop,
    input  logic              ev_txdone,
    input  logic              ev_rxclosed,
    output logic              irq,
    output logic              start_pulse,
    output logic              load_tx,
    output logic              shift_go
);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] evt_q;
    logic [REG_W-1:0] mask_q;
    logic             evt_wr;
    logic             mask_wr;
    logic             str_wr;
    logic             str_bit;

    always_comb begin
        set_vec          = '0;
        set_vec[IDX_MME] = master_mode & ss_active;
        set_vec[IDX_TXE] = ev_txerr;
        set_vec[IDX_BSY] = ev_rxdrop;
        set_vec[IDX_TXB] = ev_txdone;
        set_vec[IDX_RXB] = ev_rxclosed;
    end

    assign evt_wr  = reg_wr && (reg_addr == ADDR_EVT);
    assign mask_wr = reg_wr && (reg_addr == ADDR_MASK);
    assign str_wr  = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[STR_IDX];

    spi_evt_bank #(.W(REG_W)) u_evt (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst   (soft_rst),
        .set_vec    (set_vec),
        .clr_wr     (evt_wr),
        .clr_data   (reg_wdata),
        .evt_q      (evt_q)
    );

    spi_mask_reg #(.W(REG_W)) u_mask (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst   (soft_rst),
        .wr         (mask_wr),
        .wdata      (reg_wdata),
        .mask_q     (mask_q)
    );

    spi_cmd_fsm u_cmd (
        .clk         (clk),
        .hard_rst_n  (hard_rst_n),
        .soft_rst    (soft_rst),
        .str_wr      (str_wr),
        .master_mode (master_mode),
        .engine_idle (engine_idle),
        .ss_active   (ss_active),
        .sclk_edge   (sclk_edge),
        .start_pulse (start_pulse),
        .load_tx     (load_tx),
        .shift_go    (shift_go),
        .str_bit     (str_bit)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_EVT:  reg_rdata = evt_q;
            ADDR_MASK: reg_rdata = mask_q;
            ADDR_CMD:  reg_rdata[STR_IDX] = str_bit;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(evt_q & mask_q);

endmodule

// File: rtl/spi_evt_chk.sv
module spi_evt_chk
    import spi_evt_pkg::*;
(
    input logic              clk,
    input logic              hard_rst_n,
    input logic              soft_rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              master_mode,
    input logic              ss_active,
    input logic              engine_idle,
    input logic              ev_rxclosed,
    input logic [REG_W-1:0]  evt_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              irq,
    input logic              start_pulse,
    input logic              load_tx,
    input logic              shift_go
);

    a_r8_start_one_cycle: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        start_pulse |=> !start_pulse);

    a_r8_start_has_cause: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        $rose(start_pulse) |-> $past(reg_wr && reg_addr == ADDR_CMD && reg_wdata[STR_IDX] && master_mode));

    a_r9_load_one_cycle: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        load_tx |=> !load_tx);

    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        (reg_wr && reg_addr == ADDR_CMD && reg_wdata[STR_IDX] && !master_mode && !engine_idle) |=> !load_tx);

    a_r4_conflict_sets: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        (master_mode && ss_active) |=> evt_q[IDX_MME]);

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        ev_rxclosed |=> evt_q[IDX_RXB]);

    a_r7_irq_needs_both: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        irq |-> (evt_q != '0 && mask_q != '0));

    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!hard_rst_n || soft_rst)
        $onehot0({start_pulse, load_tx, shift_go}));

endmodule

bind spi_evt_ctl spi_evt_chk u_chk (
    .clk         (clk),
    .hard_rst_n  (hard_rst_n),
    .soft_rst    (soft_rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .master_mode (master_mode),
    .ss_active   (ss_active),
    .engine_idle (engine_idle),
    .ev_rxclosed (ev_rxclosed),
    .evt_q       (evt_q),
    .mask_q      (mask_q),
    .irq         (irq),
    .start_pulse (start_pulse),
    .load_tx     (load_tx),
    .shift_go    (shift_go)
);

// File: tb/sim_spi_evt_ctl.sv
module sim_spi_evt_ctl;

    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       master_mode = 1'b0;
    logic       ss_active = 1'b0;
    logic       sclk_edge = 1'b0;
    logic       engine_idle = 1'b1;
    logic       ev_txerr = 1'b0;
    logic       ev_rxdrop = 1'b0;
    logic       ev_txdone = 1'b0;
    logic       ev_rxclosed = 1'b0;
    logic       irq;
    logic       start_pulse;
    logic       load_tx;
    logic       shift_go;

    always #10 clk = ~clk;

    spi_evt_ctl u0 (
        .clk         (clk),
        .hard_rst_n  (hard_rst_n),
        .soft_rst    (soft_rst),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .master_mode (master_mode),
        .ss_active   (ss_active),
        .sclk_edge   (sclk_edge),
        .engine_idle (engine_idle),
        .ev_txerr    (ev_txerr),
        .ev_rxdrop   (ev_rxdrop),
        .ev_txdone   (ev_txdone),
        .ev_rxclosed (ev_rxclosed),
        .irq         (irq),
        .start_pulse (start_pulse),
        .load_tx     (load_tx),
        .shift_go    (shift_go)
    );

    // Observed signal selectors
    localparam int OBS_RDATA = 0;
    localparam int OBS_IRQ   = 1;
    localparam int OBS_START = 2;
    localparam int OBS_LOAD  = 3;
    localparam int OBS_GO    = 4;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sb[$];
    int n_checks = 0;
    int n_fails  = 0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            OBS_RDATA: return reg_rdata;
            OBS_IRQ:   return {7'b0, irq};
            OBS_START: return {7'b0, start_pulse};
            OBS_LOAD:  return {7'b0, load_tx};
            default:   return {7'b0, shift_go};
        endcase
    endfunction

    // Monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            sb_item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = observe(it.sel);
            n_checks++;
            if (got !== it.exp) begin
                n_fails++;
                $display("FAIL %s sel=%0d actual=%h expected=%h at %0t", it.req, it.sel, got, it.exp, $time);
            end
        end
    end

    task automatic expect_val(string req, int sel, logic [7:0] exp);
        sb.push_back('{req, sel, exp});
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        cyc();
        reg_wr    = 1'b0;
    endtask

    task automatic expect_reg(string req, logic [1:0] a, logic [7:0] exp);
        reg_addr = a;
        expect_val(req, OBS_RDATA, exp);
    endtask

    bit done = 1'b0;

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        hard_rst_n = 1'b1;
        cyc();
        // R1: hard reset state
        expect_reg("R1 evt", 2'd0, 8'h00);
        cyc();
        expect_reg("R1 mask", 2'd1, 8'h00);
        expect_val("R1 irq", OBS_IRQ, 8'h00);
        expect_val("R1 start", OBS_START, 8'h00);
        cyc();
        expect_reg("R1 cmd", 2'd2, 8'h00);
        cyc();

        // R3: single strobe is sticky
        ev_txerr = 1'b1;
        cyc();
        ev_txerr = 1'b0;
        expect_reg("R3 txerr", 2'd0, 8'h10);
        cyc();
        expect_reg("R3 sticky", 2'd0, 8'h10);
        ev_rxdrop = 1'b1; ev_txdone = 1'b1; ev_rxclosed = 1'b1;
        cyc();
        ev_rxdrop = 1'b0; ev_txdone = 1'b0; ev_rxclosed = 1'b0;
        expect_reg("R3 three strobes", 2'd0, 8'h17);
        cyc();

        // R5: write-one-to-clear, zeros keep
        reg_write(2'd0, 8'h02);
        expect_reg("R5 clear txb", 2'd0, 8'h15);
        reg_write(2'd0, 8'h00);
        expect_reg("R5 zeros keep", 2'd0, 8'h15);
        reg_write(2'd0, 8'hFF);
        expect_reg("R5 clear all", 2'd0, 8'h00);
        cyc();

        // R4: conflict only in master mode
        master_mode = 1'b1; ss_active = 1'b1;
        cyc();
        master_mode = 1'b0;
        expect_reg("R4 conflict", 2'd0, 8'h20);
        reg_write(2'd0, 8'h20);
        expect_reg("R4 cleared", 2'd0, 8'h00);
        cyc();
        expect_reg("R4 slave ignores ss", 2'd0, 8'h00);
        ss_active = 1'b0;
        cyc();

        // R6: set wins over clear
        ev_rxclosed = 1'b1;
        reg_write(2'd0, 8'h01);
        ev_rxclosed = 1'b0;
        expect_reg("R6 set wins", 2'd0, 8'h01);
        cyc();

        // R2: reserved bits of mask read zero
        reg_write(2'd1, 8'hFF);
        expect_reg("R2 mask live", 2'd1, 8'h37);
        // R7: irq follows event and mask
        expect_val("R7 irq on", OBS_IRQ, 8'h01);
        reg_write(2'd1, 8'h00);
        expect_val("R7 irq masked", OBS_IRQ, 8'h00);
        reg_write(2'd1, 8'h01);
        expect_val("R7 irq remasked", OBS_IRQ, 8'h01);
        reg_write(2'd0, 8'h01);
        expect_val("R7 irq cleared", OBS_IRQ, 8'h00);
        expect_reg("R2 evt empty", 2'd0, 8'h00);
        cyc();

        // R8: master start
        master_mode = 1'b1;
        reg_write(2'd2, 8'h80);
        expect_val("R8 start high", OBS_START, 8'h01);
        expect_reg("R8 cmd reads 1", 2'd2, 8'h80);
        cyc();
        expect_val("R8 start low", OBS_START, 8'h00);
        expect_reg("R8 cmd self clear", 2'd2, 8'h00);
        reg_write(2'd2, 8'h7F);
        expect_val("R8 no start", OBS_START, 8'h00);
        expect_reg("R8 cmd zero", 2'd2, 8'h00);
        cyc();

        // R9: slave start when idle
        master_mode = 1'b0; engine_idle = 1'b1;
        reg_write(2'd2, 8'h80);
        expect_val("R9 load", OBS_LOAD, 8'h01);
        expect_reg("R9 cmd", 2'd2, 8'h80);
        cyc();
        expect_val("R9 load end", OBS_LOAD, 8'h00);
        sclk_edge = 1'b1;
        cyc();
        expect_val("R9 edge without ss", OBS_GO, 8'h00);
        sclk_edge = 1'b0; ss_active = 1'b1;
        cyc();
        expect_val("R9 ss without edge", OBS_GO, 8'h00);
        sclk_edge = 1'b1;
        cyc();
        sclk_edge = 1'b0;
        expect_val("R9 go", OBS_GO, 8'h01);
        cyc();
        expect_val("R9 go end", OBS_GO, 8'h00);
        ss_active = 1'b0;
        cyc();

        // R10: slave start while busy
        engine_idle = 1'b0;
        reg_write(2'd2, 8'h80);
        expect_val("R10 no load", OBS_LOAD, 8'h00);
        expect_reg("R10 cmd", 2'd2, 8'h00);
        cyc();
        expect_val("R10 still no load", OBS_LOAD, 8'h00);
        engine_idle = 1'b1;
        cyc();

        // R1: soft reset clears registers and an armed slave start
        ev_txerr = 1'b1;
        reg_write(2'd1, 8'h10);
        ev_txerr = 1'b0;
        reg_write(2'd2, 8'h80);
        cyc();
        soft_rst = 1'b1;
        cyc();
        soft_rst = 1'b0;
        expect_reg("R1 soft evt", 2'd0, 8'h00);
        expect_val("R1 soft irq", OBS_IRQ, 8'h00);
        cyc();
        expect_reg("R1 soft mask", 2'd1, 8'h00);
        ss_active = 1'b1; sclk_edge = 1'b1;
        cyc();
        ss_active = 1'b0; sclk_edge = 1'b0;
        expect_val("R1 soft disarm", OBS_GO, 8'h00);
        cyc();
        cyc();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule